// File: doc/BRIEF.md
# Debug Break-Loop Controller

This controller sits next to the fetch stage of a small CPU and decides what happens when the break opcode (00h) is fetched. A host programs two bits in a control register: a break-loop enable and a debug request. If the break-loop enable is clear, a fetched break halts the CPU into debug mode at once. If it is set, the CPU instead spins on the break instruction. Interrupts are still serviced during the spin, and the controller raises an idle status bit.

To stop a spinning CPU safely, the host clears the break-loop enable. It does not set the debug bit, because the CPU may be inside an interrupt handler at that moment. The controller records the address of the looping break. It enters debug mode by itself only when that same break is fetched again with no interrupt in service. Host debug commands pass the command gate only while debug mode is active. A resume pulse returns the CPU to normal running.

Top module: `brk_loop_ctrl`

## Requirements
- R1: After reset, `dbg_mode`, `idle`, `stall`, `refetch` and `cmd_accept` are all low, and the break-loop enable is clear.
- R2: With the break-loop enable clear, a valid fetch of opcode 00h while running raises `dbg_mode` and `stall` on the next cycle.
- R3: With the break-loop enable set, a valid fetch of opcode 00h while running latches `fetch_addr`. On the next cycle `idle` is high, while `dbg_mode` and `stall` are low.
- R4: While looping, `refetch` is high exactly when `isr_active` is low.
- R5: A host write with `host_dbg`=1 enters debug mode on the next cycle when running. While looping it has no effect, and `idle` stays high.
- R6: While looping with the enable cleared, debug mode is entered on the next cycle only if three things hold together: a valid 00h fetch, `fetch_addr` equal to the latched address, and `isr_active` low. A fetch at another address, or one made with `isr_active` high, leaves the controller looping.
- R7: `cmd_accept` equals `cmd_valid` while debug mode is active and is low in every other state.
- R8: `host_resume` in debug mode returns the controller to running on the next cycle. In any other state it is ignored. Fetches made during debug mode have no effect.
- R9: A valid fetch of any opcode other than 00h while running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Opcode fetch strobe |
| fetch_op | input | 8 | Fetched opcode |
| fetch_addr | input | 16 | Address of the fetched opcode |
| isr_active | input | 1 | An interrupt handler is in service |
| host_wr | input | 1 | Host write strobe for the control register |
| host_dbg | input | 1 | Debug-request bit of the write |
| host_loop | input | 1 | Break-loop enable bit of the write |
| host_resume | input | 1 | Resume pulse from the host |
| cmd_valid | input | 1 | Host debug command present |
| stall | output | 1 | Halt the CPU pipeline |
| refetch | output | 1 | Repeat the break fetch |
| dbg_mode | output | 1 | Debug mode active |
| idle | output | 1 | Looping on a break instruction |
| cmd_accept | output | 1 | Host command allowed through |

## Verification
Every state change caused by a fetch, a host write or a resume is due one clock after the edge that samples it, because the state register is the only stage in that path. `refetch` and `cmd_accept` also combine that state with the present levels of `isr_active` and `cmd_valid`. The driver applies one stimulus on a falling edge and queues the outputs expected after the next rising edge. The monitor compares them 1 ns after that rising edge, while the inputs are still held, so each result is checked in exactly the cycle it becomes due.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] BRK_OP = '0;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LOOP = 2'd1,
    ST_HALT = 2'd2
  } brk_state_e;

  // break recognition kept as a function so the bench can restate it
  function automatic logic is_brk(input logic vld, input logic [OP_W-1:0] op);
    return vld && (op == BRK_OP);
  endfunction
endpackage

// File: rtl/brk_ctrl_reg.sv
module brk_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic host_dbg,
  input  logic host_loop,
  output logic loop_q,
  output logic dbg_wr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       loop_q <= 1'b0;
    else if (host_wr) loop_q <= host_loop;
  end

  // debug request is a write-only pulse, acted on by the FSM
  assign dbg_wr = host_wr && host_dbg;
endmodule

// File: rtl/brk_addr_latch.sv
module brk_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              addr_match
);
  logic [ADDR_W-1:0] saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved_q <= '0;
    else if (capture) saved_q <= fetch_addr;
  end

  assign addr_match = (fetch_addr == saved_q);
endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
  import brk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       brk_hit,
  input  logic       loop_q,
  input  logic       dbg_wr,
  input  logic       addr_match,
  input  logic       isr_active,
  input  logic       host_resume,
  output logic       capture,
  output logic       auto_go,
  output brk_state_e state_q
);
  brk_state_e state_d;

  assign capture = (state_q == ST_RUN) && brk_hit && loop_q && !dbg_wr;
  assign auto_go = (state_q == ST_LOOP) && !loop_q && brk_hit && addr_match && !isr_active;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (dbg_wr)       state_d = ST_HALT;
        else if (brk_hit) state_d = loop_q ? ST_LOOP : ST_HALT;
      end
      ST_LOOP: if (auto_go) state_d = ST_HALT;
      ST_HALT: if (host_resume) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // R2: a break with the loop enable clear halts
  a_r2_brk_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && brk_hit && !loop_q) |=> (state_q == ST_HALT));
  // R3: a break with the loop enable set spins
  a_r3_brk_loops: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (state_q == ST_LOOP));
  // R5: host debug write cannot stop a looping CPU
  a_r5_dbg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && dbg_wr && !auto_go) |=> (state_q == ST_LOOP));
  // R6: returning to the same break halts
  a_r6_auto_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && !loop_q && brk_hit && addr_match && !isr_active) |=> (state_q == ST_HALT));
  // R8: resume leaves debug, otherwise debug holds
  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && host_resume) |=> (state_q == ST_RUN));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !host_resume) |=> (state_q == ST_HALT));
endmodule

// File: rtl/brk_loop_ctrl.sv
module brk_loop_ctrl
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [OP_W-1:0]   fetch_op,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              isr_active,
  input  logic              host_wr,
  input  logic              host_dbg,
  input  logic              host_loop,
  input  logic              host_resume,
  input  logic              cmd_valid,
  output logic              stall,
  output logic              refetch,
  output logic              dbg_mode,
  output logic              idle,
  output logic              cmd_accept
);
  logic       brk_hit, loop_q, dbg_wr, addr_match, capture, auto_go;
  brk_state_e state_q;

  assign brk_hit = is_brk(fetch_valid, fetch_op);

  brk_ctrl_reg i_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_dbg(host_dbg),
    .host_loop(host_loop), .loop_q(loop_q), .dbg_wr(dbg_wr)
  );

  brk_addr_latch #(.ADDR_W(ADDR_W)) i_latch (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .fetch_addr(fetch_addr), .addr_match(addr_match)
  );

  brk_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .brk_hit(brk_hit), .loop_q(loop_q),
    .dbg_wr(dbg_wr), .addr_match(addr_match), .isr_active(isr_active),
    .host_resume(host_resume), .capture(capture), .auto_go(auto_go),
    .state_q(state_q)
  );

  assign dbg_mode   = (state_q == ST_HALT);
  assign idle       = (state_q == ST_LOOP);
  assign stall      = dbg_mode;
  assign refetch    = idle && !isr_active;
  assign cmd_accept = dbg_mode && cmd_valid;

  // R7: commands only pass when the CPU is halted
  a_r7_cmd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> stall);
  // R4: no repeat fetch while an interrupt is serviced
  a_r4_refetch_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && isr_active) |-> !refetch);
endmodule

// File: tb/test_brk_loop_ctrl.sv
`timescale 1ns/1ps
module test_brk_loop_ctrl;
  typedef struct {
    logic [4:0] exp;   // {dbg_mode, idle, stall, refetch, cmd_accept}
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 0, isr_active = 0, host_wr = 0, host_dbg = 0;
  logic host_loop = 0, host_resume = 0, cmd_valid = 0;
  logic [7:0]  fetch_op = 8'hFF;
  logic [15:0] fetch_addr = '0;
  logic stall, refetch, dbg_mode, idle, cmd_accept;
  int compared = 0, mismatched = 0;
  bit done = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  brk_loop_ctrl i_brk_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_op(fetch_op),
    .fetch_addr(fetch_addr), .isr_active(isr_active), .host_wr(host_wr),
    .host_dbg(host_dbg), .host_loop(host_loop), .host_resume(host_resume),
    .cmd_valid(cmd_valid), .stall(stall), .refetch(refetch),
    .dbg_mode(dbg_mode), .idle(idle), .cmd_accept(cmd_accept)
  );

  // monitor: result due one edge after the stimulus
  initial forever begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      item_t it = sb.pop_front();
      logic [4:0] act = {dbg_mode, idle, stall, refetch, cmd_accept};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: got %b expected %b (dbg,idle,stall,refetch,acc)", it.req, act, it.exp);
      end
    end
  end

  task automatic step(input logic fv, input logic [7:0] op, input logic [15:0] ad,
                      input logic isr, input logic wr, input logic wd, input logic wl,
                      input logic res, input logic cv, input logic [4:0] exp, input string req);
    @(negedge clk);
    fetch_valid = fv; fetch_op = op; fetch_addr = ad; isr_active = isr;
    host_wr = wr; host_dbg = wd; host_loop = wl; host_resume = res; cmd_valid = cv;
    sb.push_back('{exp, req});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    //        fv op     addr     isr wr wd wl res cv  expected
    step(0, 8'h12, 16'h0000, 0, 0, 0, 0, 0, 1, 5'b00000, "R1 reset state");
    step(0, 8'h12, 16'h0000, 0, 1, 0, 1, 0, 0, 5'b00000, "R1 enable write");
    step(1, 8'h00, 16'h0040, 0, 0, 0, 1, 0, 0, 5'b01010, "R3 break loops");
    step(0, 8'h12, 16'h0000, 0, 0, 0, 1, 0, 1, 5'b01010, "R7 blocked in loop");
    step(0, 8'h12, 16'h0000, 0, 1, 1, 1, 0, 0, 5'b01010, "R5 debug write ignored");
    step(1, 8'h3C, 16'h0100, 1, 0, 0, 0, 0, 0, 5'b01000, "R4 no refetch in isr");
    step(0, 8'h12, 16'h0000, 1, 1, 0, 0, 0, 0, 5'b01000, "R4 enable cleared in isr");
    step(1, 8'h00, 16'h0040, 1, 0, 0, 0, 0, 0, 5'b01000, "R6 isr blocks entry");
    step(1, 8'h00, 16'h0044, 0, 0, 0, 0, 0, 0, 5'b01010, "R6 address mismatch");
    step(1, 8'h00, 16'h0040, 0, 0, 0, 0, 0, 0, 5'b10100, "R6 auto entry");
    step(1, 8'h00, 16'h0300, 0, 0, 0, 0, 0, 1, 5'b10101, "R7 accepted in debug");
    step(0, 8'h12, 16'h0000, 0, 0, 0, 0, 1, 1, 5'b00000, "R8 resume");
    step(1, 8'h55, 16'h0010, 0, 0, 0, 0, 0, 0, 5'b00000, "R9 other opcode");
    step(0, 8'h12, 16'h0000, 0, 0, 0, 0, 1, 0, 5'b00000, "R8 resume ignored running");
    step(1, 8'h00, 16'h0200, 0, 0, 0, 0, 0, 0, 5'b10100, "R2 break halts");
    step(1, 8'h00, 16'h0200, 0, 0, 0, 0, 0, 0, 5'b10100, "R8 fetch ignored in debug");
    step(0, 8'h12, 16'h0000, 0, 0, 0, 0, 1, 0, 5'b00000, "R8 resume again");
    step(0, 8'h12, 16'h0000, 0, 1, 1, 0, 0, 0, 5'b10100, "R5 debug write halts");
    step(0, 8'h12, 16'h0000, 0, 0, 0, 0, 1, 0, 5'b00000, "R8 resume after write");
    step(0, 8'h12, 16'h0000, 0, 0, 0, 0, 0, 0, 5'b00000, "R9 quiet");
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule